// File: doc/BRIEF.md
# Multithreaded instruction retirement controller

This block is the last stop of an in-order pipeline shared by several hardware threads. Each request names a thread, a sequence number, a command, a fault flag with fault code, the pipeline stage that issued it and a non-speculative flag. Two commands exist. A fault check either passes quietly or, when the instruction carries a fault, sends a squash-and-trap notice back to the earlier stages and answers with failure. A graduate command retires the instruction, signals completion to the core and, for a non-speculative instruction, lifts that thread's non-speculative block.

Time is counted in core cycles marked by a strobe input, not in block clocks. Several requests may fall inside one core cycle. Within a core cycle each thread may retire at most one non-speculative instruction. A thread with a pending trap retires nothing. A rejected request still gets a response, with success low. The issue stage raises a thread's non-speculative block through a separate set port.

Requests use a valid/ready handshake and are taken one per clock. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low during reset and for the first clock after it, then stays high, so the only back-pressure is the reset window. The response is not held and cannot be stalled: it is valid for exactly one clock.

Top module: `retire_ctrl`

## Requirements
- R1: While reset is held, `req_ready`, `rsp_done`, `sq_valid` and `ret_valid` are low and every `ns_active` bit is 0. `req_ready` is high from the second clock after reset is released.
- R2: Each accepted request yields exactly one `rsp_done` pulse, on the clock after acceptance. Back-to-back requests give back-to-back responses, and there is no response without a request.
- R3: A thread ID of `NTHREADS` or more gives `rsp_done`=1, `rsp_ok`=0 and `rsp_err`=1, with no squash, no retire and no state change.
- R4: Command codes are 2'b01 for fault check and 2'b10 for graduate. Codes 2'b00 and 2'b11 give `rsp_err`=1 and `rsp_ok`=0.
- R5: When `trap_pending[t]` is set, a request of thread t is rejected (`rsp_ok`=0, `rsp_err`=0) with no squash and no retire pulse.
- R6: After a non-speculative graduation of thread t, every later request of thread t in the same core cycle is rejected (`rsp_ok`=0, `rsp_err`=0). Other threads are not affected. The core cycle advances on the clock edge at which `cyc_strobe` is high, so a request sampled at that edge still belongs to the old core cycle.
- R7: A fault check whose request has `req_fault`=1 answers with `rsp_ok`=0 and pulses `sq_valid` with that request's thread, sequence, stage and fault code. `fault_seen[t]` then reads 1 until the core cycle advances.
- R8: A fault check with `req_fault`=0 answers with `rsp_ok`=1 and pulses neither `sq_valid` nor `ret_valid`.
- R9: A graduate command that is not rejected answers with `rsp_ok`=1 and pulses `ret_valid` with the request's thread and sequence, whatever `req_fault` is.
- R10: A non-speculative graduation of thread t clears `ns_active[t]`.
- R11: `ns_set_valid` with a valid thread sets `ns_active[t]` and stores `ns_set_seq` in `ns_block_seq` slice t (bits t*SEQ_W up). When a set and a clear hit the same thread on the same edge, the set wins.
- R12: The checks apply in this order: bad thread ID (error), then same-core-cycle non-speculative reject, then trap reject, then command decode. A trapped thread given an unknown command is therefore rejected without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_strobe | input | 1 | Core-cycle advance strobe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_tid | input | TID_W | Thread ID |
| req_seq | input | SEQ_W | Sequence number |
| req_cmd | input | 2 | Command code |
| req_fault | input | 1 | Instruction carries a fault |
| req_fault_code | input | FC_W | Fault code |
| req_nonspec | input | 1 | Instruction is non-speculative |
| req_stage | input | STG_W | Issuing stage number |
| trap_pending | input | NTHREADS | Per-thread trap-pending flags |
| ns_set_valid | input | 1 | Raise a thread's non-speculative block |
| ns_set_tid | input | TID_W | Thread for the block |
| ns_set_seq | input | SEQ_W | Sequence of the blocking instruction |
| rsp_done | output | 1 | Response valid |
| rsp_ok | output | 1 | Request succeeded |
| rsp_err | output | 1 | Bad thread ID or command |
| sq_valid | output | 1 | Squash-and-trap pulse |
| sq_tid | output | TID_W | Squash thread |
| sq_seq | output | SEQ_W | Squash sequence |
| sq_stage | output | STG_W | Squash stage |
| sq_code | output | FC_W | Squash fault code |
| ret_valid | output | 1 | Instruction-done pulse |
| ret_tid | output | TID_W | Retired thread |
| ret_seq | output | SEQ_W | Retired sequence |
| ns_active | output | NTHREADS | Non-speculative block flags |
| ns_block_seq | output | NTHREADS*SEQ_W | Blocking sequence per thread |
| fault_seen | output | NTHREADS | Fault recorded in the current core cycle |

## Verification
A non-speculative graduation and a block set from the issue stage can hit the same thread on one clock edge, and the same edge can also advance the core cycle. The bench drives `ns_set_valid` on the same edge as a non-speculative graduate of that thread and checks that `ns_active` stays 1 with the new sequence, as R11 requires. It also issues same-thread requests with `cyc_strobe` high on the retiring edge, to confirm that the request sampled on that edge is still rejected and the next one is accepted.

// File: rtl/retire_pkg.sv
package retire_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_CHECK = 2'b01,
    CMD_GRAD  = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic ok;
    logic err;
    logic squash;
    logic retire;
    logic ns_clr;
    logic fault_rec;
  } verdict_t;

endpackage

// File: rtl/retire_epoch.sv
module retire_epoch #(
  parameter int EP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  output logic [EP_W-1:0] epoch
);

  logic [EP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (strobe) cnt_q <= cnt_q + 1'b1;
  end

  assign epoch = cnt_q;

endmodule

// File: rtl/retire_thread_slot.sv
module retire_thread_slot #(
  parameter int SEQ_W = 16,
  parameter int EP_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EP_W-1:0]  epoch,
  input  logic             set_en,
  input  logic [SEQ_W-1:0] set_seq,
  input  logic             clr_en,
  input  logic             fault_en,
  output logic             active,
  output logic [SEQ_W-1:0] blk_seq,
  output logic             ns_hit,
  output logic             fault_hit
);

  logic             active_q;
  logic [SEQ_W-1:0] seq_q;
  logic             ns_vld_q, ft_vld_q;
  logic [EP_W-1:0]  ns_ep_q, ft_ep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      seq_q    <= '0;
    end else if (set_en) begin
      active_q <= 1'b1;
      seq_q    <= set_seq;
    end else if (clr_en) begin
      active_q <= 1'b0;
    end
  end

  // Stamps carry a valid bit so that epoch 0 after reset is not a hit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_vld_q <= 1'b0;
      ns_ep_q  <= '0;
      ft_vld_q <= 1'b0;
      ft_ep_q  <= '0;
    end else begin
      if (clr_en) begin
        ns_vld_q <= 1'b1;
        ns_ep_q  <= epoch;
      end
      if (fault_en) begin
        ft_vld_q <= 1'b1;
        ft_ep_q  <= epoch;
      end
    end
  end

  assign active    = active_q;
  assign blk_seq   = seq_q;
  assign ns_hit    = ns_vld_q && (ns_ep_q == epoch);
  assign fault_hit = ft_vld_q && (ft_ep_q == epoch);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !active);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (active && blk_seq == $past(set_seq)));

endmodule

// File: rtl/retire_decide.sv
module retire_decide
  import retire_pkg::*;
(
  input  logic     tid_ok,
  input  logic     ns_hit,
  input  logic     trap,
  input  cmd_e     cmd,
  input  logic     fault,
  input  logic     nonspec,
  output verdict_t v
);

  always_comb begin
    v = '0;
    if (!tid_ok) begin
      v.err = 1'b1;
    end else if (ns_hit || trap) begin
      v = '0;
    end else begin
      unique case (cmd)
        CMD_CHECK: begin
          if (fault) begin
            v.squash    = 1'b1;
            v.fault_rec = 1'b1;
          end else begin
            v.ok = 1'b1;
          end
        end
        CMD_GRAD: begin
          v.ok     = 1'b1;
          v.retire = 1'b1;
          v.ns_clr = nonspec;
        end
        default: v.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int TID_W    = 3,
  parameter int SEQ_W    = 16,
  parameter int STG_W    = 3,
  parameter int FC_W     = 4,
  parameter int EP_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cyc_strobe,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [TID_W-1:0]          req_tid,
  input  logic [SEQ_W-1:0]          req_seq,
  input  logic [1:0]                req_cmd,
  input  logic                      req_fault,
  input  logic [FC_W-1:0]           req_fault_code,
  input  logic                      req_nonspec,
  input  logic [STG_W-1:0]          req_stage,
  input  logic [NTHREADS-1:0]       trap_pending,
  input  logic                      ns_set_valid,
  input  logic [TID_W-1:0]          ns_set_tid,
  input  logic [SEQ_W-1:0]          ns_set_seq,
  output logic                      rsp_done,
  output logic                      rsp_ok,
  output logic                      rsp_err,
  output logic                      sq_valid,
  output logic [TID_W-1:0]          sq_tid,
  output logic [SEQ_W-1:0]          sq_seq,
  output logic [STG_W-1:0]          sq_stage,
  output logic [FC_W-1:0]           sq_code,
  output logic                      ret_valid,
  output logic [TID_W-1:0]          ret_tid,
  output logic [SEQ_W-1:0]          ret_seq,
  output logic [NTHREADS-1:0]       ns_active,
  output logic [NTHREADS*SEQ_W-1:0] ns_block_seq,
  output logic [NTHREADS-1:0]       fault_seen
);

  localparam int IDX_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1;

  logic                ready_q;
  logic                accept;
  logic                tid_ok, set_ok;
  logic [IDX_W-1:0]    idx;
  logic [EP_W-1:0]     epoch;
  logic [NTHREADS-1:0] ns_hit_vec;
  verdict_t            v;

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;
  assign tid_ok    = int'(req_tid) < NTHREADS;
  assign set_ok    = int'(ns_set_tid) < NTHREADS;
  assign idx       = req_tid[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  retire_epoch #(.EP_W(EP_W)) u_epoch (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cyc_strobe),
    .epoch  (epoch)
  );

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    logic hit_me;
    assign hit_me = accept && tid_ok && (idx == IDX_W'(t));

    retire_thread_slot #(.SEQ_W(SEQ_W), .EP_W(EP_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .epoch     (epoch),
      .set_en    (ns_set_valid && set_ok && (ns_set_tid == TID_W'(t))),
      .set_seq   (ns_set_seq),
      .clr_en    (hit_me && v.ns_clr),
      .fault_en  (hit_me && v.fault_rec),
      .active    (ns_active[t]),
      .blk_seq   (ns_block_seq[t*SEQ_W +: SEQ_W]),
      .ns_hit    (ns_hit_vec[t]),
      .fault_hit (fault_seen[t])
    );
  end

  retire_decide u_decide (
    .tid_ok  (tid_ok),
    .ns_hit  (tid_ok ? ns_hit_vec[idx] : 1'b0),
    .trap    (tid_ok ? trap_pending[idx] : 1'b0),
    .cmd     (cmd_e'(req_cmd)),
    .fault   (req_fault),
    .nonspec (req_nonspec),
    .v       (v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      sq_valid  <= 1'b0;
      ret_valid <= 1'b0;
    end else begin
      rsp_done  <= accept;
      rsp_ok    <= accept && v.ok;
      rsp_err   <= accept && v.err;
      sq_valid  <= accept && v.squash;
      ret_valid <= accept && v.retire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_tid   <= '0;
      sq_seq   <= '0;
      sq_stage <= '0;
      sq_code  <= '0;
      ret_tid  <= '0;
      ret_seq  <= '0;
    end else if (accept) begin
      sq_tid   <= req_tid;
      sq_seq   <= req_seq;
      sq_stage <= req_stage;
      sq_code  <= req_fault_code;
      ret_tid  <= req_tid;
      ret_seq  <= req_seq;
    end
  end

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!req_ready && !rsp_done && !sq_valid && !ret_valid));

  assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_done);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_done);

  assert_err_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_done && !rsp_ok && !sq_valid && !ret_valid));

  assert_trap_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tid_ok && trap_pending[idx]) |=>
      (!ret_valid && !sq_valid && !rsp_ok));

  assert_squash_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> (rsp_done && !rsp_ok && !ret_valid));

  assert_retire_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (rsp_done && rsp_ok));

endmodule

// File: tb/retire_ctrl_test.sv
module retire_ctrl_test;

  localparam int N = 4, TW = 3, SW = 16, GW = 3, FW = 4;

  logic clk = 1'b0, rst_n = 1'b0, cyc_strobe = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [TW-1:0] req_tid = '0;
  logic [SW-1:0] req_seq = '0;
  logic [1:0] req_cmd = '0;
  logic req_fault = 1'b0, req_nonspec = 1'b0;
  logic [FW-1:0] req_fault_code = '0;
  logic [GW-1:0] req_stage = '0;
  logic [N-1:0] trap_pending = '0;
  logic ns_set_valid = 1'b0;
  logic [TW-1:0] ns_set_tid = '0;
  logic [SW-1:0] ns_set_seq = '0;
  logic rsp_done, rsp_ok, rsp_err, sq_valid, ret_valid;
  logic [TW-1:0] sq_tid, ret_tid;
  logic [SW-1:0] sq_seq, ret_seq;
  logic [GW-1:0] sq_stage;
  logic [FW-1:0] sq_code;
  logic [N-1:0] ns_active, fault_seen;
  logic [N*SW-1:0] ns_block_seq;

  retire_ctrl uut (.*);

  always #5 clk = ~clk;

  typedef struct {
    int due; logic ok; logic err; logic sq; logic ret;
    logic [TW-1:0] tid; logic [SW-1:0] seq;
    logic [GW-1:0] stg; logic [FW-1:0] code; string tag;
  } exp_t;

  exp_t sbq[$];
  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: sets the request at a falling edge and records the expected response.
  task automatic put(input int tid, input int seq, input int cmd, input bit flt,
                     input int code, input bit ns, input int stg, input bit stb,
                     input bit ok, input bit err, input bit sq, input bit ret,
                     input string tag);
    exp_t e;
    req_valid = 1'b1; req_tid = TW'(tid); req_seq = SW'(seq); req_cmd = 2'(cmd);
    req_fault = flt; req_fault_code = FW'(code); req_nonspec = ns;
    req_stage = GW'(stg); cyc_strobe = stb;
    e.due = cyc + 1; e.ok = ok; e.err = err; e.sq = sq; e.ret = ret;
    e.tid = TW'(tid); e.seq = SW'(seq); e.stg = GW'(stg); e.code = FW'(code); e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic req(input int tid, input int seq, input int cmd, input bit flt,
                     input int code, input bit ns, input int stg, input bit stb,
                     input bit ok, input bit err, input bit sq, input bit ret,
                     input string tag);
    @(negedge clk);
    put(tid, seq, cmd, flt, code, ns, stg, stb, ok, err, sq, ret, tag);
  endtask

  task automatic idle(input bit stb);
    @(negedge clk);
    req_valid = 1'b0; ns_set_valid = 1'b0; cyc_strobe = stb;
  endtask

  // Monitor: pops the scoreboard when a response is due.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        exp_t e;
        e = sbq.pop_front();
        check(rsp_done == 1'b1, {e.tag, " done"}, rsp_done, 1);
        check(rsp_ok == e.ok, {e.tag, " ok"}, rsp_ok, e.ok);
        check(rsp_err == e.err, {e.tag, " err"}, rsp_err, e.err);
        check(sq_valid == e.sq, {e.tag, " squash"}, sq_valid, e.sq);
        check(ret_valid == e.ret, {e.tag, " retire"}, ret_valid, e.ret);
        if (e.sq)
          check(sq_tid == e.tid && sq_seq == e.seq && sq_stage == e.stg && sq_code == e.code,
                {e.tag, " squash fields"}, {sq_tid, sq_seq, sq_stage, sq_code},
                {e.tid, e.seq, e.stg, e.code});
        if (e.ret)
          check(ret_tid == e.tid && ret_seq == e.seq, {e.tag, " retire fields"},
                {ret_tid, ret_seq}, {e.tid, e.seq});
      end else if (rsp_done || sq_valid || ret_valid) begin
        check(1'b0, "R2 unexpected response", {rsp_done, sq_valid, ret_valid}, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 0 && rsp_done == 0 && sq_valid == 0 && ret_valid == 0,
          "R1 outputs in reset", {req_ready, rsp_done, sq_valid, ret_valid}, 0);
    check(ns_active == '0, "R1 ns_active in reset", ns_active, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // R11: set a block on thread 1
    ns_set_valid = 1'b1; ns_set_tid = 3'd1; ns_set_seq = 16'h0055;
    idle(1'b1);
    check(ns_active == 4'b0010, "R11 set flag", ns_active, 4'b0010);
    check(ns_block_seq[SW +: SW] == 16'h0055, "R11 block seq", ns_block_seq[SW +: SW], 16'h55);

    // R8, R7, R9, R2 back-to-back
    req(0, 16'h0010, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R8 clean check");
    req(2, 16'h0020, 1, 1, 5, 0, 3, 0, 0, 0, 1, 0, "R7 fault check");
    idle(1'b0);
    check(fault_seen == 4'b0100, "R7 fault seen", fault_seen, 4'b0100);
    idle(1'b1);
    idle(1'b1);
    check(fault_seen == 4'b0000, "R7 fault cleared by new cycle", fault_seen, 0);
    req(0, 16'h0030, 2, 1, 7, 0, 2, 1, 1, 0, 0, 1, "R9 graduate ignores fault");
    req(3, 16'h0031, 2, 0, 0, 0, 2, 1, 1, 0, 0, 1, "R2 back-to-back graduate");

    // R6, R10: one non-speculative graduation per thread per core cycle
    req(1, 16'h0055, 2, 0, 0, 1, 4, 0, 1, 0, 0, 1, "R10 nonspec graduate");
    req(1, 16'h0056, 2, 0, 0, 0, 4, 0, 0, 0, 0, 0, "R6 same-cycle reject");
    req(3, 16'h0057, 2, 0, 0, 1, 4, 0, 1, 0, 0, 1, "R6 other thread free");
    req(1, 16'h0058, 2, 0, 0, 0, 4, 1, 0, 0, 0, 0, "R6 reject on strobe edge");
    req(1, 16'h0059, 2, 0, 0, 0, 4, 1, 1, 0, 0, 1, "R6 accepted next cycle");
    idle(1'b1);
    check(ns_active == 4'b0000, "R10 block cleared", ns_active, 0);

    // R5: trap pending
    trap_pending = 4'b1000;
    req(3, 16'h0060, 2, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 trap blocks graduate");
    req(3, 16'h0061, 1, 1, 2, 0, 1, 1, 0, 0, 0, 0, "R5 trap blocks fault check");
    req(3, 16'h0062, 3, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R12 trap before bad command");
    req(2, 16'h0063, 2, 0, 0, 0, 1, 1, 1, 0, 0, 1, "R5 other thread unaffected");
    idle(1'b1);
    trap_pending = '0;

    // R3, R4, R12
    req(5, 16'h0070, 2, 0, 0, 1, 1, 1, 0, 1, 0, 0, "R3 bad thread id");
    req(4, 16'h0071, 1, 1, 1, 0, 1, 1, 0, 1, 0, 0, "R12 bad thread before fault");
    req(0, 16'h0072, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0, "R4 command 00");
    req(0, 16'h0073, 3, 0, 0, 0, 1, 1, 0, 1, 0, 0, "R4 command 11");
    idle(1'b1);
    check(ns_active == 4'b0000 && fault_seen == 4'b0000, "R3 no state change",
          {ns_active, fault_seen}, 0);

    // R11: set and clear on the same edge, set wins
    ns_set_valid = 1'b1; ns_set_tid = 3'd2; ns_set_seq = 16'h0100;
    idle(1'b1);
    check(ns_active == 4'b0100, "R11 second set", ns_active, 4'b0100);
    @(negedge clk);
    ns_set_valid = 1'b1; ns_set_tid = 3'd2; ns_set_seq = 16'h0077;
    put(2, 16'h0100, 2, 0, 0, 1, 5, 1, 1, 0, 0, 1, "R11 graduate with same-edge set");
    idle(1'b1);
    check(ns_active == 4'b0100, "R11 set wins over clear", ns_active, 4'b0100);
    check(ns_block_seq[2*SW +: SW] == 16'h0077, "R11 new block seq",
          ns_block_seq[2*SW +: SW], 16'h77);

    repeat (3) idle(1'b1);
    check(sbq.size() == 0, "R2 all responses seen", sbq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule